// File: doc/BRIEF.md
# Light Output On/Off Time Protector

This block guards the drive signals of several light outputs against two kinds of misuse of the lamp. A lamp should not stay lit longer than a programmed ceiling, and it should not be relit before a programmed rest period has passed since it last went dark. Each output has an activation request, which comes from an upstream source selector. The block turns that request into a protected drive signal for the output stage.

Time is counted in milliseconds, using a one-cycle tick pulse supplied from outside. Each channel has its own 8-bit on-time ceiling and its own 8-bit rest time, each with a separate enable. A request that arrives during the rest period is not dropped. It is held back and served as soon as the rest period ends, provided the request is still asserted. A drive that reaches the ceiling is cut, and it stays dark until the request is released and asserted again.

Top module: `lamp_guard`

## Requirements
- R1: While reset is held, every drive output is 0, whatever the requests are. Right after reset a channel counts as fully rested, so a request is served within two clock cycles even when the rest limit is 255 and enabled.
- R2: With both enables of a channel at 0, its drive equals its request delayed by exactly one clock cycle.
- R3: With the on-time limit enabled and set to L (1 to 255), a drive that stays lit is forced to 0 at the clock edge that samples the L-th tick counted since it rose.
- R4: After a forced cut, the drive stays 0 while the request stays high. It may light again only after the request has been 0 for at least one cycle and then returns to 1.
- R5: With the rest limit enabled and set to M (1 to 255), the drive cannot rise until M ticks have been counted since it last fell. A request made earlier is postponed, and the drive rises one cycle after the clock edge that samples the M-th tick.
- R6: The rest period is measured from the falling edge of the drive, including a forced cut, and not from the falling edge of the request.
- R7: A postponed turn-on is dropped if the request falls before the rest period ends. It leaves no pulse behind after the rest period ends.
- R8: The two enables act independently. With only the rest limit enabled, lit periods are never cut. With only the on-time limit enabled, a relight is never postponed.
- R9: The channels are independent. Activity or a cut on one channel does not change the drive of another.
- R10: The tick counters saturate at 255 and do not wrap. A drive lit for more than 255 ticks while the ceiling was disabled is cut within two cycles once the ceiling is enabled with the limit 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse, once per millisecond |
| req | input | NCH | Activation request, one bit per channel |
| on_lim | input | NCH*8 | On-time ceiling in ticks, channel k in bits [8k+7:8k] |
| on_en | input | NCH | Enable of the on-time ceiling, per channel |
| off_lim | input | NCH*8 | Rest time in ticks, channel k in bits [8k+7:8k] |
| off_en | input | NCH | Enable of the rest time, per channel |
| drive | output | NCH | Protected drive, one bit per channel |

## Verification
The assertions assume that a limit and its enable only change while the channel's drive is low, with one exception: the ceiling may be enabled while the drive is lit. They also assume that the tick is a single-cycle pulse with at least one idle cycle between pulses. The stimulus produces every tick through a task that pulses it for one cycle and then holds it low for a cycle. It reprograms limits only while the drive is dark, or at a point where a cut is the intended result. It uses limit values from 1 to 255 only.

// File: rtl/lamp_guard_pkg.sv
package lamp_guard_pkg;
    parameter int LG_CNT_W = 8;

    typedef struct packed {
        logic                drv;
        logic                lock;
        logic [LG_CNT_W-1:0] on_cnt;
        logic [LG_CNT_W-1:0] off_cnt;
    } lg_state_t;
endpackage

// File: rtl/lamp_guard_satcnt.sv
module lamp_guard_satcnt #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt_i,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = '1;

    always_comb begin
        if (clr_i)
            cnt_o = '0;
        else if (inc_i && cnt_i != TOP)
            cnt_o = cnt_i + 1'b1;
        else
            cnt_o = cnt_i;
    end
endmodule

// File: rtl/lamp_guard_chan.sv
module lamp_guard_chan
    import lamp_guard_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_ms,
    input  logic                req,
    input  logic [LG_CNT_W-1:0] on_lim,
    input  logic                on_en,
    input  logic [LG_CNT_W-1:0] off_lim,
    input  logic                off_en,
    output logic                drive
);
    localparam logic [LG_CNT_W-1:0] CNT_TOP = '1;

    lg_state_t st_q, st_d;
    logic [LG_CNT_W-1:0] on_next, off_next;
    logic cut, rested;

    // lit-time counter: cleared while dark
    lamp_guard_satcnt #(.W(LG_CNT_W)) u_on_cnt (
        .cnt_i(st_q.on_cnt), .inc_i(tick_ms), .clr_i(!st_q.drv), .cnt_o(on_next)
    );
    // dark-time counter: cleared while lit, so it starts at the drive's fall
    lamp_guard_satcnt #(.W(LG_CNT_W)) u_off_cnt (
        .cnt_i(st_q.off_cnt), .inc_i(tick_ms), .clr_i(st_q.drv), .cnt_o(off_next)
    );

    always_comb begin
        cut    = st_q.drv && on_en && (on_next >= on_lim);
        rested = !off_en || (st_q.off_cnt >= off_lim);
        st_d         = st_q;
        st_d.on_cnt  = on_next;
        st_d.off_cnt = off_next;
        if (st_q.drv) begin
            st_d.drv  = req && !cut;
            st_d.lock = req && cut;
        end else begin
            st_d.drv  = req && !st_q.lock && rested;
            st_d.lock = st_q.lock && req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.drv     <= 1'b0;
            st_q.lock    <= 1'b0;
            st_q.on_cnt  <= '0;
            st_q.off_cnt <= CNT_TOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive = st_q.drv;

    assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_en && !off_en && !st_q.lock) |=> (st_q.drv == $past(req)));

    assert_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.drv && on_en && st_q.on_cnt >= on_lim) |=> !st_q.drv);

    assert_lock_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |-> !st_q.drv);

    assert_relight_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.drv) |-> ($past(req) && !$past(st_q.lock)));

    assert_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.drv) && $past(off_en)) |-> ($past(st_q.off_cnt) >= $past(off_lim)));

    assert_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.drv && st_q.off_cnt == CNT_TOP) |=> (st_q.off_cnt == CNT_TOP));
endmodule

// File: rtl/lamp_guard.sv
module lamp_guard
    import lamp_guard_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_ms,
    input  logic [NCH-1:0]          req,
    input  logic [NCH*LG_CNT_W-1:0] on_lim,
    input  logic [NCH-1:0]          on_en,
    input  logic [NCH*LG_CNT_W-1:0] off_lim,
    input  logic [NCH-1:0]          off_en,
    output logic [NCH-1:0]          drive
);
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        lamp_guard_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_ms (tick_ms),
            .req     (req[g]),
            .on_lim  (on_lim[g*LG_CNT_W +: LG_CNT_W]),
            .on_en   (on_en[g]),
            .off_lim (off_lim[g*LG_CNT_W +: LG_CNT_W]),
            .off_en  (off_en[g]),
            .drive   (drive[g])
        );
    end
endmodule

// File: tb/lamp_guard_bench.sv
`timescale 1ns/1ps
module lamp_guard_bench;
    localparam int NCH = 4;
    localparam int W   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0;
    logic [NCH-1:0]   req = '0, on_en = '0, off_en = '0;
    logic [NCH*W-1:0] on_lim = '0, off_lim = '0;
    logic [NCH-1:0]   drive;
    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lamp_guard #(.NCH(NCH)) u_lamp_guard (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .req(req),
        .on_lim(on_lim), .on_en(on_en), .off_lim(off_lim), .off_en(off_en),
        .drive(drive)
    );

    // {request applied, drive expected before applying it}
    localparam logic [1:0] VEC [12] = '{
        2'b10, 2'b11, 2'b01, 2'b10, 2'b01, 2'b00,
        2'b10, 2'b11, 2'b11, 2'b01, 2'b10, 2'b01
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_ms = 1'b1;
            @(negedge clk); tick_ms = 1'b0;
        end
    endtask

    task automatic set0(input logic oe, input int ol, input logic fe, input int fl);
        on_en[0] = oe; on_lim[W-1:0] = W'(ol);
        off_en[0] = fe; off_lim[W-1:0] = W'(fl);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        req = '1;
        wait_neg(3);
        for (int c = 0; c < NCH; c++) chk($sformatf("R1 reset ch%0d", c), drive[c], 1'b0);
        req = '0;
        rst_n = 1'b1;
        // R1: fully rested at start
        set0(0, 1, 1, 255);
        req[0] = 1'b1;
        wait_neg(2);
        chk("R1 rested after reset", drive[0], 1'b1);
        req[0] = 1'b0; set0(0, 1, 0, 1);
        wait_neg(2);

        // R2: vector walk, pass-through latency
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk($sformatf("R2 vector %0d", i), drive[0], VEC[i][0]);
            req[0] = VEC[i][1];
        end
        @(negedge clk); req[0] = 1'b0;
        wait_neg(2);

        // R3, R4, R9
        req[1] = 1'b1;
        set0(1, 3, 0, 1);
        req[0] = 1'b1;
        wait_neg(2);
        chk("R3 lit before limit", drive[0], 1'b1);
        ticks(2);
        chk("R3 still lit after L-1 ticks", drive[0], 1'b1);
        ticks(1);
        chk("R3 cut at L-th tick", drive[0], 1'b0);
        chk("R9 ch1 unaffected", drive[1], 1'b1);
        chk("R9 ch2 idle", drive[2], 1'b0);
        ticks(2);
        chk("R4 stays dark while request held", drive[0], 1'b0);
        req[0] = 1'b0; @(negedge clk); req[0] = 1'b1;
        wait_neg(2);
        chk("R4 relight after release", drive[0], 1'b1);
        req[0] = 1'b0; req[1] = 1'b0;
        wait_neg(2);

        // R5: rest period
        set0(0, 1, 1, 4);
        req[0] = 1'b1;
        ticks(4); wait_neg(1);
        chk("R5 lit after rest", drive[0], 1'b1);
        req[0] = 1'b0; @(negedge clk); req[0] = 1'b1;
        wait_neg(2);
        chk("R5 postponed", drive[0], 1'b0);
        ticks(3);
        chk("R5 still postponed at M-1", drive[0], 1'b0);
        ticks(1); wait_neg(1);
        chk("R5 lit after M ticks", drive[0], 1'b1);

        // R6: rest measured from the cut
        set0(1, 2, 1, 3);
        ticks(2);
        chk("R6 cut", drive[0], 1'b0);
        ticks(2);
        req[0] = 1'b0; @(negedge clk); req[0] = 1'b1;
        wait_neg(2);
        chk("R6 rest not yet over", drive[0], 1'b0);
        ticks(1); wait_neg(1);
        chk("R6 rest counted from drive fall", drive[0], 1'b1);
        req[0] = 1'b0;
        wait_neg(2);

        // R7: abandoned postponement
        set0(0, 1, 1, 5);
        req[0] = 1'b1;
        wait_neg(2);
        chk("R7 postponed", drive[0], 1'b0);
        ticks(2);
        req[0] = 1'b0;
        ticks(5); wait_neg(2);
        chk("R7 no leftover pulse", drive[0], 1'b0);
        req[0] = 1'b1;
        wait_neg(2);
        chk("R7 fresh request served", drive[0], 1'b1);

        // R8: independent enables
        set0(0, 2, 1, 5);
        ticks(5);
        chk("R8 no cut with ceiling disabled", drive[0], 1'b1);
        set0(1, 200, 0, 5);
        req[0] = 1'b0; @(negedge clk); req[0] = 1'b1;
        wait_neg(2);
        chk("R8 no postponement with rest disabled", drive[0], 1'b1);

        // R10: saturation
        set0(0, 255, 0, 1);
        ticks(300);
        chk("R10 lit long with ceiling off", drive[0], 1'b1);
        set0(1, 255, 0, 1);
        wait_neg(2);
        chk("R10 saturated counter cuts", drive[0], 1'b0);
        req[0] = 1'b0;
        wait_neg(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule